// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog timer reached through a small word-wide register bus. Software arms it through a restart register: writing the word 0x000000A5 and then the word 0x0000005A completes an unlock. The next write to the control register may then set the run bit. While the timer runs, the same two-word pair restarts the count, which is the periodic feed that shows software is still alive.

One free-running count drives two expiry events. The shorter interval sets an interrupt flag, and that flag drives an interrupt line when its enable is set. The longer interval issues a one-cycle system reset request, but only if reset requests are enabled. The request also sets a sticky bit that records that the watchdog caused a reset.

The block has two reset inputs. Power-on reset clears every control field. The system reset, which the watchdog itself triggers, clears only the count and the unlock tracker, so the control fields and the sticky bit can still be read after a watchdog reset.

Top module: `wdt_keyed`

## Requirements
- R1: Control sits at offset 0x0 and restart at offset 0x4. Control bit 8 is run enable, bit 9 is the interrupt flag, bit 10 is interrupt enable, bit 11 is reset enable, and bit 31 is the watchdog-reset record. Control bits 30:12 and 7:0 read as 0 and ignore writes. The restart offset reads as 0.
- R2: Power-on reset (rst_ni low) clears every control field to 0. System reset (sys_rst_ni low) leaves the control fields unchanged and clears the count and the unlock tracker.
- R3: A control write with bit 8 = 1 starts a stopped timer only if restart writes of 0xA5 and then 0x5A came before it. Any control write uses up a completed unlock. If the timer already runs, writing bit 8 = 1 keeps it running.
- R4: Any restart write between 0xA5 and 0x5A that is neither value cancels the sequence, so a later 0x5A does not complete it.
- R5: Writing bit 8 = 0 stops the timer and clears the count to 0.
- R6: The interrupt flag sets 2^INT_LOG2 cycles after the count starts from 0. Writing 1 to bit 9 clears the flag, and writing 0 to bit 9 leaves it unchanged.
- R7: irq_o is high exactly while the interrupt flag and interrupt enable are both 1.
- R8: When reset enable is 1, rst_req_o pulses high for one cycle 2^RST_LOG2 cycles after the count starts from 0. The same pulse sets bit 31, and the count restarts from 0.
- R9: When reset enable is 0, the reset interval passes with no rst_req_o pulse and bit 31 unchanged.
- R10: The 0xA5, 0x5A pair written to restart while the timer runs clears the count to 0 (a feed).
- R11: Software can set and clear bit 31 by writing to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous; clears count and unlock tracker only |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational on addr_i |
| irq_o | output | 1 | Interrupt line |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest states to reach are the ones where ordering decides the result: an unlock cut short by a wrong word, an unlock half done when a system reset arrives, and a feed that lands just before the interrupt interval expires. Directed tasks place each bus write on a known edge, count the cycles from the enabling write, and check the flag one cycle before and one cycle after the edge where it must set. This shows whether the count was cleared or kept. A system reset is pulsed between the two key words to show that the tracker forgets the first word while the control fields stay intact.

// File: rtl/wdt_keyed_pkg.sv
`timescale 1ns/1ps
package wdt_keyed_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  localparam int OFS_CTRL    = 0;
  localparam int OFS_RESTART = 4;

  localparam int BIT_RUN   = 8;
  localparam int BIT_IFLAG = 9;
  localparam int BIT_IEN   = 10;
  localparam int BIT_REN   = 11;
  localparam int BIT_RFLAG = 31;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
endpackage

// File: rtl/wdt_key_tracker.sv
`timescale 1ns/1ps
module wdt_key_tracker
  import wdt_keyed_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              consume_i,
  output logic              key_done_o,
  output logic              unlocked_o
);
  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

  key_state_e state_q;
  logic       unlocked_q;

  assign key_done_o = wr_i && (wdata_i == K2) && (state_q == KEY_ARMED);
  assign unlocked_o = unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_IDLE;
    end else if (wr_i) begin
      state_q <= (wdata_i == K1) ? KEY_ARMED : KEY_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
    end else if (key_done_o) begin
      unlocked_q <= 1'b1;
    end else if (consume_i) begin
      unlocked_q <= 1'b0;
    end
  end

  // unlock only ever appears right after the second key word
  assert_unlock_after_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_q) |-> $past(wr_i && (wdata_i == K2)));
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int INT_LOG2 = 4,
  parameter int RST_LOG2 = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic int_hit_o,
  output logic rst_hit_o
);
  localparam int CNT_W = RST_LOG2;
  localparam logic [CNT_W-1:0] INT_LAST =
    {{(RST_LOG2-INT_LOG2){1'b0}}, {INT_LOG2{1'b1}}};

  logic [CNT_W-1:0] cnt_q;

  assign int_hit_o = run_i && (cnt_q == INT_LAST);
  assign rst_hit_o = run_i && (&cnt_q);

  // all-ones wraps to zero, so the reset expiry restarts the count by itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || clear_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_idle_count_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  assert_feed_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_ctrl_regs.sv
`timescale 1ns/1ps
module wdt_ctrl_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_rflag_i,
  input  logic wr_ren_i,
  input  logic wr_ien_i,
  input  logic wr_iclr_i,
  input  logic wr_run_i,
  input  logic unlocked_i,
  input  logic int_hit_i,
  input  logic rst_hit_i,
  output logic run_o,
  output logic ien_o,
  output logic ren_o,
  output logic iflag_o,
  output logic rflag_o,
  output logic rst_req_o
);
  logic run_q, ien_q, ren_q, iflag_q, rflag_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      ren_q   <= 1'b0;
      iflag_q <= 1'b0;
      rflag_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= rst_hit_i && ren_q;
      if (wr_i) begin
        ien_q <= wr_ien_i;
        ren_q <= wr_ren_i;
        run_q <= wr_run_i && (run_q || unlocked_i);
      end
      // hardware set wins over a same-cycle software write
      if (rst_hit_i && ren_q)     rflag_q <= 1'b1;
      else if (wr_i)              rflag_q <= wr_rflag_i;
      if (int_hit_i)              iflag_q <= 1'b1;
      else if (wr_i && wr_iclr_i) iflag_q <= 1'b0;
    end
  end

  assign run_o     = run_q;
  assign ien_o     = ien_q;
  assign ren_o     = ren_q;
  assign iflag_o   = iflag_q;
  assign rflag_o   = rflag_q;
  assign rst_req_o = req_q;

  assert_enable_keyed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(unlocked_i));
  assert_iflag_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iflag_q) |-> $past(wr_i && wr_iclr_i));
  assert_req_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_req_sets_record_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> rflag_q);
  assert_req_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(ren_q));
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int INT_LOG2 = 4,
  parameter int RST_LOG2 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);

  logic ctrl_wr, restart_wr, cnt_rst_n;
  logic key_done, unlocked;
  logic run, ien, ren, iflag, rflag;
  logic int_hit, rst_hit;

  assign ctrl_wr    = req_i && we_i && (addr_i == A_CTRL);
  assign restart_wr = req_i && we_i && (addr_i == A_RESTART);
  assign cnt_rst_n  = rst_ni && sys_rst_ni;

  wdt_key_tracker #(.DATA_W(DATA_W)) u_keys (
    .clk_i      (clk_i),
    .rst_ni     (cnt_rst_n),
    .wr_i       (restart_wr),
    .wdata_i    (wdata_i),
    .consume_i  (ctrl_wr),
    .key_done_o (key_done),
    .unlocked_o (unlocked)
  );

  wdt_counter #(.INT_LOG2(INT_LOG2), .RST_LOG2(RST_LOG2)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (cnt_rst_n),
    .run_i     (run),
    .clear_i   (key_done),
    .int_hit_o (int_hit),
    .rst_hit_o (rst_hit)
  );

  wdt_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .wr_rflag_i (wdata_i[BIT_RFLAG]),
    .wr_ren_i   (wdata_i[BIT_REN]),
    .wr_ien_i   (wdata_i[BIT_IEN]),
    .wr_iclr_i  (wdata_i[BIT_IFLAG]),
    .wr_run_i   (wdata_i[BIT_RUN]),
    .unlocked_i (unlocked),
    .int_hit_i  (int_hit),
    .rst_hit_i  (rst_hit),
    .run_o      (run),
    .ien_o      (ien),
    .ren_o      (ren),
    .iflag_o    (iflag),
    .rflag_o    (rflag),
    .rst_req_o  (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[BIT_RFLAG] = rflag;
      rdata_o[BIT_REN]   = ren;
      rdata_o[BIT_IEN]   = ien;
      rdata_o[BIT_IFLAG] = iflag;
      rdata_o[BIT_RUN]   = run;
    end
  end

  assign irq_o = iflag && ien;

  initial begin
    assert (INT_LOG2 > 0 && RST_LOG2 > INT_LOG2)
      else $error("wdt_keyed: need 0 < INT_LOG2 < RST_LOG2");
  end

  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (u_regs.iflag_o && u_regs.ien_o));
endmodule

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;
  localparam int INT_LOG2 = 4;
  localparam int RST_LOG2 = 7;
  localparam int INT_CYC  = 1 << INT_LOG2;
  localparam int RST_CYC  = 1 << RST_LOG2;
  localparam logic [31:0] RUN = 32'h100, IFL = 32'h200, IEN = 32'h400,
                          REN = 32'h800, RFL = 32'h8000_0000;

  logic clk = 1'b0, rst_ni = 1'b0, sys_rst_ni = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rst_req;
  int checks = 0, fails = 0, pulses = 0;

  always #5 clk = ~clk;

  wdt_keyed #(.INT_LOG2(INT_LOG2), .RST_LOG2(RST_LOG2)) u_wdt_keyed (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_ni(sys_rst_ni), .req_i(req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rst_req));

  always @(negedge clk) if (rst_req) pulses++;

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; addr = 4'h0; wdata = '0;
  endtask

  task automatic keys();
    wr(4'h4, 32'hA5);
    wr(4'h4, 32'h5A);
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic por();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_reset_state();
    por();
    check("R2 por ctrl", rdata, 32'h0);
    check("R2 por irq", {31'b0, irq}, 32'h0);
    check("R2 por rst_req", {31'b0, rst_req}, 32'h0);
  endtask

  task automatic t_regmap();
    por();
    wr(4'h0, 32'h7FFF_F0FF);
    check("R1 reserved bits", rdata, 32'h0);
    wr(4'h0, IEN | REN);
    check("R1 enable fields", rdata, IEN | REN);
    @(negedge clk); addr = 4'h4; #1;
    check("R1 restart reads 0", rdata, 32'h0);
    addr = 4'h0;
    wr(4'h0, RFL);
    check("R11 set record", rdata, RFL);
    wr(4'h0, 32'h0);
    check("R11 clear record", rdata, 32'h0);
  endtask

  task automatic t_key_enable();
    por();
    wr(4'h0, RUN);
    check("R3 no key", rdata, 32'h0);
    wr(4'h4, 32'h5A); wr(4'h0, RUN);
    check("R3 second key only", rdata, 32'h0);
    keys(); wr(4'h0, RUN);
    check("R3 keyed enable", rdata, RUN);
    wr(4'h0, RUN | IEN);
    check("R3 stays running", rdata, RUN | IEN);
  endtask

  task automatic t_key_abort();
    por();
    wr(4'h4, 32'hA5); wr(4'h4, 32'h33); wr(4'h4, 32'h5A);
    wr(4'h0, RUN);
    check("R4 broken sequence", rdata, 32'h0);
  endtask

  task automatic t_disable();
    por();
    keys(); wr(4'h0, RUN);
    cycles(10);
    wr(4'h0, 32'h0);
    check("R5 stopped", rdata, 32'h0);
    cycles(20);
    check("R5 no flag while stopped", rdata, 32'h0);
    keys(); wr(4'h0, RUN);
    cycles(INT_CYC - 1);
    check("R5 count restarted", rdata & IFL, 32'h0);
    cycles(1);
    check("R5 flag at interval", rdata & IFL, IFL);
  endtask

  task automatic t_int_flag();
    por();
    wr(4'h0, IEN); keys(); wr(4'h0, IEN | RUN);
    cycles(INT_CYC - 1);
    check("R6 flag before interval", rdata & IFL, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);
    cycles(1);
    check("R6 flag at interval", rdata & IFL, IFL);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    wr(4'h0, IEN | RUN);
    check("R6 write 0 keeps flag", rdata & IFL, IFL);
    wr(4'h0, RUN);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(4'h0, RUN | IFL);
    check("R6 w1c clears", rdata & IFL, 32'h0);
  endtask

  task automatic t_reset_req();
    int p0;
    por();
    wr(4'h0, IEN | REN); keys();
    p0 = pulses;
    wr(4'h0, IEN | REN | RUN);
    cycles(RST_CYC - 1);
    check("R8 no request early", {31'b0, rst_req}, 32'h0);
    cycles(1);
    check("R8 request pulse", {31'b0, rst_req}, 32'h1);
    check("R8 record set", rdata & RFL, RFL);
    cycles(1);
    check("R8 single cycle", {31'b0, rst_req}, 32'h0);
    check("R8 one pulse", pulses - p0, 32'd1);
    wr(4'h0, IEN | REN | RUN | IFL);
    cycles(INT_CYC - 3);
    check("R8 count restarted", rdata & IFL, 32'h0);
    cycles(1);
    check("R8 flag after restart", rdata & IFL, IFL);
  endtask

  task automatic t_no_reset();
    int p0;
    por();
    keys();
    p0 = pulses;
    wr(4'h0, IEN | RUN);
    cycles(RST_CYC + 12);
    check("R9 no request", pulses - p0, 32'd0);
    check("R9 record clear", rdata & RFL, 32'h0);
  endtask

  task automatic t_feed();
    por();
    keys(); wr(4'h0, RUN);
    cycles(INT_CYC - 3);
    keys();
    cycles(INT_CYC - 1);
    check("R10 feed restarted count", rdata & IFL, 32'h0);
    cycles(1);
    check("R10 flag after feed", rdata & IFL, IFL);
  endtask

  task automatic t_sys_reset();
    por();
    wr(4'h0, IEN | REN | RFL);
    wr(4'h4, 32'hA5);
    @(negedge clk); sys_rst_ni = 1'b0;
    @(negedge clk); sys_rst_ni = 1'b1; #1;
    check("R2 fields survive sys reset", rdata, IEN | REN | RFL);
    wr(4'h4, 32'h5A);
    wr(4'h0, IEN | REN | RFL | RUN);
    check("R2 tracker cleared", rdata & RUN, 32'h0);
    keys(); wr(4'h0, IEN | RUN);
    cycles(INT_CYC - 2);
    @(negedge clk); sys_rst_ni = 1'b0;
    @(negedge clk); sys_rst_ni = 1'b1; #1;
    cycles(INT_CYC - 1);
    check("R2 count cleared by sys reset", rdata & IFL, 32'h0);
    cycles(1);
    check("R2 flag after sys reset", rdata & IFL, IFL);
    por();
    check("R2 por clears fields", rdata, 32'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    t_regmap();
    t_key_enable();
    t_key_abort();
    t_disable();
    t_int_flag();
    t_reset_req();
    t_no_reset();
    t_feed();
    t_sys_reset();
    summary();
    $finish;
  end
endmodule